// File: doc/BRIEF.md
# Gated Frequency Counter with Timestamp Capture

This block measures an unknown signal against a once-per-second gate pulse. A free-running event counter counts rising edges of the unknown signal. A second free-running counter counts system clock cycles. Both counters are extended by wrap counters, so software downstream can subtract successive captures without losing whole turns of either counter. On each rising edge of the gate, the block takes a snapshot of both counters.

Each snapshot becomes a record: a sequence number, an extension count and the captured count. The measured record and the reference record are pushed into two separate first-word-fall-through buffers. Downstream logic drains them through a simple pop interface and computes frequency from the differences between records.

The gate and the unknown signal are asynchronous. Each passes through a two-flop synchronizer, so the measurable rate stays below half the system clock. On its way to the reference capture, the gate also passes through a digital filter that samples every fourth clock. When a buffer is full, its new records are discarded and a sticky drop flag is raised. The flag stays set until a clear pulse arrives.

Top module: `pps_freq_counter`

## Requirements
- R1: While `rst` is high and on the cycle after it, both buffers report empty, both drop flags read 0, and all counters, extension counts and sequence numbers are 0.
- R2: The measured count is a `LO_W`-bit low stage below a `HI_W`-bit high stage. The low stage advances by one on each synchronized rising edge of `sig_in`. The high stage advances when the low stage rolls over from all ones.
- R3: The measured extension count advances by one each time the whole measured count rolls over from all ones to zero.
- R4: On each synchronized rising gate edge, the block pushes a measured record. The record's count field equals the number of `sig_in` rising edges detected before that gate edge.
- R5: Each record's sequence number is the previous one plus one. The first record after reset carries 1. The number advances on every capture, including captures that are dropped, so a gap in the sequence marks lost records. Each buffer keeps its own sequence.
- R6: The reference counter advances by one on every clock and wraps from all ones to zero. Its extension count advances on each wrap.
- R7: The reference capture uses a filtered copy of the gate. The synchronized gate is sampled once every 4 clocks. The filtered level changes only after `FILT_N` consecutive equal samples, and its rising edge pushes a reference record. When gate rises are spaced a multiple of 4 clocks apart, two successive reference records differ by exactly that spacing.
- R8: Each buffer shows its oldest record on its read data port whenever its empty output is 0. A one-cycle read enable removes that record. A read enable while the buffer is empty has no effect.
- R9: A record that arrives at a full buffer is discarded, the records already stored are unchanged, and that buffer's drop flag goes to 1.
- R10: A drop flag stays at 1 until a one-cycle `drop_clear` pulse, which returns it to 0.
- Record layout for both buffers: bits [C-1:0] hold the count, where C is `LO_W+HI_W` for measured records and `REF_W` for reference records. The next `EXT_W` bits hold the extension count. The top `SEQ_W` bits hold the sequence number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also clocks the reference counter |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Asynchronous signal whose edges are counted |
| gate_in | input | 1 | Asynchronous once-per-second gate pulse |
| meas_rd_en | input | 1 | Pop the oldest measured record |
| meas_rd_data | output | SEQ_W+EXT_W+LO_W+HI_W | Oldest measured record |
| meas_empty | output | 1 | Measured buffer holds no record |
| meas_drop_flag | output | 1 | Sticky: a measured record was discarded |
| ref_rd_en | input | 1 | Pop the oldest reference record |
| ref_rd_data | output | SEQ_W+EXT_W+REF_W | Oldest reference record |
| ref_empty | output | 1 | Reference buffer holds no record |
| ref_drop_flag | output | 1 | Sticky: a reference record was discarded |
| drop_clear | input | 1 | Clears both drop flags |

## Verification
An error in the low/high stage carry or in the extension counter shows up in the first record taken after the affected rollover. The bench therefore drives enough edges to cross the low-stage, high-stage and extension boundaries of a narrow configuration. Any mistake in the filter latency or the reference increment breaks the exact spacing between consecutive reference records. This appears on the second record after the fault. A sequence or buffer-pointer fault surfaces as a wrong sequence number, a wrong count or a wrong empty flag on the very next pop, including the pops that follow a deliberate overflow of a four-entry buffer.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    // the reference gate filter takes one sample every SAMPLE_DIV clocks
    localparam int SAMPLE_DIV = 4;

    function automatic logic rising(input logic prev, input logic cur);
        return cur & ~prev;
    endfunction

    function automatic logic all_ones_or_zeros(input logic ones, input logic zeros);
        return ones | zeros;
    endfunction

endpackage

// File: rtl/pfc_sync2.sv
module pfc_sync2 (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [1:0] ff;

    always_ff @(posedge clk) begin
        if (rst) ff <= '0;
        else     ff <= {ff[0], din};
    end

    assign dout = ff[1];
endmodule

// File: rtl/pfc_gate_filter.sv
module pfc_gate_filter #(
    parameter int FILT_N = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise_o
);
    import pfc_pkg::*;

    localparam int DIV_W = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;

    logic [DIV_W-1:0]  div;
    logic              tick;
    logic [FILT_N-1:0] hist, hist_nxt;
    logic              level;
    logic              all_hi, all_lo;

    assign tick   = (div == DIV_W'(SAMPLE_DIV - 1));
    assign all_hi = &hist;
    assign all_lo = ~|hist;

    generate
        if (FILT_N == 1) begin : g_single
            assign hist_nxt = din;
        end else begin : g_shift
            assign hist_nxt = {hist[FILT_N-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            div    <= '0;
            hist   <= '0;
            level  <= 1'b0;
            rise_o <= 1'b0;
        end else begin
            div    <= tick ? '0 : div + 1'b1;
            if (tick) hist <= hist_nxt;
            rise_o <= !level && all_hi;
            if (all_ones_or_zeros(all_hi, all_lo)) level <= all_hi;
        end
    end

    // R7: a filtered rise is a single-cycle pulse
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);
    // R7: a pulse is only issued once the filtered level has become high
    a_r7_level_high: assert property (@(posedge clk) disable iff (rst)
        rise_o |-> level);
    // R7: the sample history only moves on a sample tick
    a_r7_hist_on_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(hist));
endmodule

// File: rtl/pfc_rec_fifo.sv
module pfc_rec_fifo #(
    parameter int W  = 64,
    parameter int AW = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         drop_flag,
    input  logic         drop_clear
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp;
    logic         full, push, pop;

    assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign empty = (wp == rp);
    assign push  = wr_en && !full;
    assign pop   = rd_en && !empty;

    always_ff @(posedge clk) begin
        if (push) mem[wp[AW-1:0]] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp        <= '0;
            rp        <= '0;
            drop_flag <= 1'b0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            if (wr_en && full)   drop_flag <= 1'b1;
            else if (drop_clear) drop_flag <= 1'b0;
        end
    end

    assign rd_data = mem[rp[AW-1:0]];

    // R9: a write into a full buffer raises the drop flag
    a_r9_drop_sets_flag: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full) |=> drop_flag);
    // R9: a discarded write does not move the write pointer
    a_r9_full_no_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full) |=> $stable(wp));
    // R8: a read on an empty buffer leaves it empty
    a_r8_empty_pop_ignored: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty && !wr_en) |=> empty);
    // R10: the drop flag holds until cleared
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (drop_flag && !drop_clear) |=> drop_flag);
    // R10: a clear with no concurrent drop empties the flag
    a_r10_flag_cleared: assert property (@(posedge clk) disable iff (rst)
        (drop_clear && !(wr_en && full)) |=> !drop_flag);
endmodule

// File: rtl/pps_freq_counter.sv
module pps_freq_counter #(
    parameter int LO_W    = 16,
    parameter int HI_W    = 16,
    parameter int REF_W   = 32,
    parameter int EXT_W   = 16,
    parameter int SEQ_W   = 16,
    parameter int FIFO_AW = 10,
    parameter int FILT_N  = 2,
    localparam int CNT_W  = LO_W + HI_W,
    localparam int MREC_W = SEQ_W + EXT_W + CNT_W,
    localparam int RREC_W = SEQ_W + EXT_W + REF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sig_in,
    input  logic              gate_in,
    input  logic              meas_rd_en,
    output logic [MREC_W-1:0] meas_rd_data,
    output logic              meas_empty,
    output logic              meas_drop_flag,
    input  logic              ref_rd_en,
    output logic [RREC_W-1:0] ref_rd_data,
    output logic              ref_empty,
    output logic              ref_drop_flag,
    input  logic              drop_clear
);
    import pfc_pkg::*;

    // ---------------- input conditioning ----------------
    logic sig_s, gate_s, sig_q, gate_q;
    logic sig_rise, gate_rise, gate_rise_ref;

    pfc_sync2 u_sig_sync  (.clk(clk), .rst(rst), .din(sig_in),  .dout(sig_s));
    pfc_sync2 u_gate_sync (.clk(clk), .rst(rst), .din(gate_in), .dout(gate_s));

    always_ff @(posedge clk) begin
        if (rst) begin
            sig_q  <= 1'b0;
            gate_q <= 1'b0;
        end else begin
            sig_q  <= sig_s;
            gate_q <= gate_s;
        end
    end

    assign sig_rise  = rising(sig_q, sig_s);
    assign gate_rise = rising(gate_q, gate_s);

    pfc_gate_filter #(.FILT_N(FILT_N)) u_filt (
        .clk(clk), .rst(rst), .din(gate_s), .rise_o(gate_rise_ref)
    );

    // ---------------- measured event counter ----------------
    logic [LO_W-1:0]  m_lo;
    logic [HI_W-1:0]  m_hi;
    logic [EXT_W-1:0] m_ext;
    logic [SEQ_W-1:0] m_seq, m_seq_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            m_lo  <= '0;
            m_hi  <= '0;
            m_ext <= '0;
        end else if (sig_rise) begin
            m_lo <= m_lo + 1'b1;
            if (&m_lo) begin
                m_hi <= m_hi + 1'b1;
                if (&m_hi) m_ext <= m_ext + 1'b1;
            end
        end
    end

    assign m_seq_nxt = m_seq + 1'b1;

    always_ff @(posedge clk) begin
        if (rst)            m_seq <= '0;
        else if (gate_rise) m_seq <= m_seq_nxt;
    end

    // ---------------- reference clock counter ----------------
    logic [REF_W-1:0] r_cnt;
    logic [EXT_W-1:0] r_ext;
    logic [SEQ_W-1:0] r_seq, r_seq_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            r_cnt <= '0;
            r_ext <= '0;
        end else begin
            r_cnt <= r_cnt + 1'b1;
            if (&r_cnt) r_ext <= r_ext + 1'b1;
        end
    end

    assign r_seq_nxt = r_seq + 1'b1;

    always_ff @(posedge clk) begin
        if (rst)                r_seq <= '0;
        else if (gate_rise_ref) r_seq <= r_seq_nxt;
    end

    // ---------------- record buffers ----------------
    pfc_rec_fifo #(.W(MREC_W), .AW(FIFO_AW)) u_meas_fifo (
        .clk(clk), .rst(rst),
        .wr_en(gate_rise), .wr_data({m_seq_nxt, m_ext, m_hi, m_lo}),
        .rd_en(meas_rd_en), .rd_data(meas_rd_data), .empty(meas_empty),
        .drop_flag(meas_drop_flag), .drop_clear(drop_clear)
    );

    pfc_rec_fifo #(.W(RREC_W), .AW(FIFO_AW)) u_ref_fifo (
        .clk(clk), .rst(rst),
        .wr_en(gate_rise_ref), .wr_data({r_seq_nxt, r_ext, r_cnt}),
        .rd_en(ref_rd_en), .rd_data(ref_rd_data), .empty(ref_empty),
        .drop_flag(ref_drop_flag), .drop_clear(drop_clear)
    );

    // R2: each detected edge adds exactly one to the measured count
    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        sig_rise |=> ({m_hi, m_lo} == $past({m_hi, m_lo}) + 1'b1));
    // R2: no detected edge, no change
    a_r2_count_hold: assert property (@(posedge clk) disable iff (rst)
        !sig_rise |=> $stable({m_ext, m_hi, m_lo}));
    // R3: the full rollover advances the extension count
    a_r3_ext_wrap: assert property (@(posedge clk) disable iff (rst)
        (sig_rise && (&{m_hi, m_lo})) |=> (m_ext == $past(m_ext) + 1'b1));
    // R5: each measured capture advances the sequence by one
    a_r5_meas_seq: assert property (@(posedge clk) disable iff (rst)
        gate_rise |=> (m_seq == $past(m_seq) + 1'b1));
    // R5: each reference capture advances its own sequence by one
    a_r5_ref_seq: assert property (@(posedge clk) disable iff (rst)
        gate_rise_ref |=> (r_seq == $past(r_seq) + 1'b1));
    // R6: the reference counter moves by one every clock
    a_r6_ref_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (r_cnt == $past(r_cnt) + 1'b1));
endmodule

// File: tb/sim_pps_freq_counter.sv
module sim_pps_freq_counter;
    localparam int LO_W = 4, HI_W = 4, REF_W = 8, EXT_W = 8, SEQ_W = 8;
    localparam int AW = 2, FILT_N = 2;

    logic clk = 1'b0;
    logic rst, sig_in, gate_in, meas_rd_en, ref_rd_en, drop_clear;
    logic [23:0] meas_rd_data, ref_rd_data;
    logic meas_empty, ref_empty, meas_drop_flag, ref_drop_flag;

    always #2.5 clk = ~clk;

    pps_freq_counter #(
        .LO_W(LO_W), .HI_W(HI_W), .REF_W(REF_W), .EXT_W(EXT_W),
        .SEQ_W(SEQ_W), .FIFO_AW(AW), .FILT_N(FILT_N)
    ) u0 (
        .clk(clk), .rst(rst), .sig_in(sig_in), .gate_in(gate_in),
        .meas_rd_en(meas_rd_en), .meas_rd_data(meas_rd_data),
        .meas_empty(meas_empty), .meas_drop_flag(meas_drop_flag),
        .ref_rd_en(ref_rd_en), .ref_rd_data(ref_rd_data),
        .ref_empty(ref_empty), .ref_drop_flag(ref_drop_flag),
        .drop_clear(drop_clear)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    longint exp_meas [0:39];
    int     per      [0:39];
    longint ref_full [0:39];
    bit     have_ref [0:39];
    longint total = 0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_pair(input int k);
        longint rf;
        chk("R8", "measured buffer not empty", meas_empty, 0);
        chk("R2", "measured count field", meas_rd_data[7:0], exp_meas[k] & 255);
        chk("R3", "measured extension field", meas_rd_data[15:8], (exp_meas[k] >> 8) & 255);
        chk("R4", "measured record total", meas_rd_data[15:0], exp_meas[k] & 16'hFFFF);
        chk("R5", "measured sequence", meas_rd_data[23:16], (k + 1) & 255);
        chk("R8", "reference buffer not empty", ref_empty, 0);
        chk("R5", "reference sequence", ref_rd_data[23:16], (k + 1) & 255);
        rf = ref_rd_data[15:0];
        if (k > 0 && have_ref[k-1])
            chk("R6 R7", "reference spacing", (rf - ref_full[k-1]) & 16'hFFFF, per[k-1]);
        ref_full[k] = rf;
        have_ref[k] = 1'b1;
    endtask

    task automatic run_window(input int k, input int n, input bit rd_on);
        int p;
        p = 4 * n + 20;
        p = (p + 3) / 4 * 4;
        if (p < 64) p = 64;
        per[k]      = p;
        exp_meas[k] = total;
        for (int c = 0; c < p; c++) begin
            @(negedge clk);
            if (rd_on && c == p - 4) check_pair(k);
            gate_in    = (c < 24);
            sig_in     = (c >= 4 && c < 4 + 4 * n) ? (((c - 4) % 4) < 2) : 1'b0;
            meas_rd_en = rd_on && (c == p - 4);
            ref_rd_en  = rd_on && (c == p - 4);
        end
        total += n;
    endtask

    task automatic pop_only(input int k);
        @(negedge clk);
        check_pair(k);
        meas_rd_en = 1'b1;
        ref_rd_en  = 1'b1;
        @(negedge clk);
        meas_rd_en = 1'b0;
        ref_rd_en  = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; sig_in = 1'b0; gate_in = 1'b0;
        meas_rd_en = 1'b0; ref_rd_en = 1'b0; drop_clear = 1'b0;
        for (int i = 0; i < 40; i++) have_ref[i] = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1", "measured empty in reset", meas_empty, 1);
        chk("R1", "reference empty in reset", ref_empty, 1);
        chk("R1", "measured drop flag in reset", meas_drop_flag, 0);
        chk("R1", "reference drop flag in reset", ref_drop_flag, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "measured empty after reset", meas_empty, 1);
        chk("R1", "reference empty after reset", ref_empty, 1);

        // sweep of edge counts per window, crossing low, high and extension rollovers
        for (int k = 0; k < 20; k++) run_window(k, k, 1'b1);
        run_window(20, 70, 1'b1);
        run_window(21, 130, 1'b1);
        run_window(22, 3, 1'b1);

        // overflow: six captures into four-entry buffers with no reads
        for (int k = 23; k < 29; k++) run_window(k, 1, 1'b0);
        @(negedge clk);
        chk("R9", "measured drop flag after overflow", meas_drop_flag, 1);
        chk("R9", "reference drop flag after overflow", ref_drop_flag, 1);
        for (int k = 23; k < 27; k++) pop_only(k);
        @(negedge clk);
        chk("R8", "measured empty after drain", meas_empty, 1);
        chk("R8", "reference empty after drain", ref_empty, 1);

        // read on empty must not disturb anything
        meas_rd_en = 1'b1; ref_rd_en = 1'b1;
        @(negedge clk);
        meas_rd_en = 1'b0; ref_rd_en = 1'b0;
        @(negedge clk);
        chk("R8", "measured stays empty on empty read", meas_empty, 1);
        chk("R8", "reference stays empty on empty read", ref_empty, 1);
        chk("R10", "measured flag holds without clear", meas_drop_flag, 1);
        chk("R10", "reference flag holds without clear", ref_drop_flag, 1);

        drop_clear = 1'b1;
        @(negedge clk);
        drop_clear = 1'b0;
        chk("R10", "measured flag cleared", meas_drop_flag, 0);
        chk("R10", "reference flag cleared", ref_drop_flag, 0);

        // after the gap: sequence shows the two dropped captures
        run_window(29, 2, 1'b1);
        run_window(30, 5, 1'b1);
        @(negedge clk);
        chk("R10", "measured flag stays clear", meas_drop_flag, 0);
        chk("R8", "measured empty at end", meas_empty, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule